// File: doc/BRIEF.md
# Half-Precision Compare Flag Unit

This unit takes two 16-bit half-precision floating-point operands and reduces their relation to a small condition-flag word. It distinguishes four outcomes (greater, less, equal, unordered) and encodes them on the zero, parity and carry flags. The overflow, sign and auxiliary flags are always cleared. A mode bit chooses between an ordered compare and a quiet compare. The two modes differ only in which NaN inputs raise the invalid-operation exception.

Each operand is classified on its own as zero, subnormal, quiet NaN or signaling NaN, and the two operands are then ordered. The flag word, a one-cycle write pulse and two sticky status bits (invalid and denormal) are registered. If an exception is raised while its mask bit is clear, the flag word keeps its old contents and no write pulse is issued. A suppress input turns all exception reporting off for one operation.

Top module: `hcmp_flag_unit`

## Requirements
- R1: If either operand is a NaN (exponent all ones, mantissa nonzero), the result is unordered and the zero, parity and carry flags are all 1.
- R2: If operand A is greater than operand B, the zero, parity and carry flags are all 0.
- R3: If operand A is less than operand B, only the carry flag is 1.
- R4: If the operands are equal, only the zero flag is 1. +0 and -0 count as equal.
- R5: The flag word has carry in bit 0, parity in bit 1, auxiliary in bit 2, zero in bit 3, sign in bit 4 and overflow in bit 5. Bits 2, 4 and 5 are always 0.
- R6: With quiet_i=0 (ordered), invalid is raised for any NaN operand. With quiet_i=1, invalid is raised only for a signaling NaN, which is a NaN whose mantissa bit 9 is 0.
- R7: Denormal is raised when an operand has exponent 0 and a nonzero mantissa. Subnormal operands compare by their true value.
- R8: When a raised exception has its mask bit at 0, flag_we_o stays low and flags_o keeps its previous value. When every raised exception is masked, the write goes ahead.
- R9: While sup_i=1, no status bit is set and the flags are always written.
- R10: flags_o and flag_we_o appear on the clock edge that samples vld_i. When vld_i is low there is no write. Reset clears the flags and both status bits.
- R11: inv_sticky_o and dnm_sticky_o stay at 1 once set, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vld_i | input | 1 | Operation strobe |
| quiet_i | input | 1 | 1 selects the quiet compare, 0 the ordered compare |
| a_i | input | 16 | Operand A |
| b_i | input | 16 | Operand B |
| inv_mask_i | input | 1 | 1 masks the invalid exception |
| dnm_mask_i | input | 1 | 1 masks the denormal exception |
| sup_i | input | 1 | Suppress all exception reporting |
| flags_o | output | 6 | Registered flag word |
| flag_we_o | output | 1 | Flag write pulse |
| inv_sticky_o | output | 1 | Sticky invalid status |
| dnm_sticky_o | output | 1 | Sticky denormal status |

## Verification
Random operands are drawn from signed zeros, subnormals, infinities, quiet and signaling NaNs and random normals. Copying A into B forces the equal case, and swapping A and B separates greater from less. Quiet and signaling NaNs in both modes show the two invalid rules apart. Random mask and suppress settings show where a write is blocked, where it goes through masked, and where it is forced. Directed cases cover -0 against +0, the ordering of subnormals near zero, idle cycles and a reset in the middle of the run.

// File: rtl/hcmp_pkg.sv
package hcmp_pkg;

   typedef enum logic [1:0] {
      CMP_GT = 2'd0,
      CMP_LT = 2'd1,
      CMP_EQ = 2'd2,
      CMP_UN = 2'd3
   } cmp_res_e;

   typedef struct packed {
      logic is_nan;
      logic is_snan;
      logic is_zero;
      logic is_dnm;
   } op_class_t;

   localparam int FLG_W  = 6;
   localparam int FLG_CF = 0;
   localparam int FLG_PF = 1;
   localparam int FLG_AF = 2;
   localparam int FLG_ZF = 3;
   localparam int FLG_SF = 4;
   localparam int FLG_OF = 5;

endpackage

// File: rtl/hcmp_classify.sv
module hcmp_classify
   import hcmp_pkg::*;
#(
   parameter int EXP_W = 5,
   parameter int MAN_W = 10,
   localparam int W = 1 + EXP_W + MAN_W
) (
   input  logic [W-1:0] op_i,
   output op_class_t    cls_o
);
   logic [EXP_W-1:0] exp_f;
   logic [MAN_W-1:0] man_f;
   logic exp_ones, exp_zero, man_nz;

   assign exp_f    = op_i[W-2 -: EXP_W];
   assign man_f    = op_i[MAN_W-1:0];
   assign exp_ones = &exp_f;
   assign exp_zero = ~|exp_f;
   assign man_nz   = |man_f;

   always_comb begin
      cls_o.is_nan  = exp_ones & man_nz;
      cls_o.is_snan = exp_ones & man_nz & ~man_f[MAN_W-1];
      cls_o.is_zero = exp_zero & ~man_nz;
      cls_o.is_dnm  = exp_zero & man_nz;
   end
endmodule

// File: rtl/hcmp_order.sv
module hcmp_order
   import hcmp_pkg::*;
#(
   parameter int W = 16
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  op_class_t    cls_a_i,
   input  op_class_t    cls_b_i,
   output cmp_res_e     res_o
);
   logic [W-2:0] mag_a, mag_b;
   logic sgn_a, sgn_b, mag_lt, mag_eq;

   assign mag_a  = a_i[W-2:0];
   assign mag_b  = b_i[W-2:0];
   assign sgn_a  = a_i[W-1];
   assign sgn_b  = b_i[W-1];
   assign mag_lt = mag_a < mag_b;
   assign mag_eq = mag_a == mag_b;

   always_comb begin
      if (cls_a_i.is_nan || cls_b_i.is_nan)
         res_o = CMP_UN;
      else if (cls_a_i.is_zero && cls_b_i.is_zero)
         res_o = CMP_EQ;
      else if (sgn_a != sgn_b)
         res_o = sgn_a ? CMP_LT : CMP_GT;
      else if (mag_eq)
         res_o = CMP_EQ;
      else if (!sgn_a)
         res_o = mag_lt ? CMP_LT : CMP_GT;
      else
         res_o = mag_lt ? CMP_GT : CMP_LT;
   end
endmodule

// File: rtl/hcmp_flag_reg.sv
module hcmp_flag_reg
   import hcmp_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             vld_i,
   input  cmp_res_e         res_i,
   input  logic             inv_raise_i,
   input  logic             dnm_raise_i,
   input  logic             inv_mask_i,
   input  logic             dnm_mask_i,
   input  logic             sup_i,
   output logic [FLG_W-1:0] flags_o,
   output logic             flag_we_o,
   output logic             inv_sticky_o,
   output logic             dnm_sticky_o
);
   logic [FLG_W-1:0] flags_nxt;
   logic unmasked_hit, write_ok;

   always_comb begin
      flags_nxt = '0;
      unique case (res_i)
         CMP_UN: begin
            flags_nxt[FLG_ZF] = 1'b1;
            flags_nxt[FLG_PF] = 1'b1;
            flags_nxt[FLG_CF] = 1'b1;
         end
         CMP_LT:  flags_nxt[FLG_CF] = 1'b1;
         CMP_EQ:  flags_nxt[FLG_ZF] = 1'b1;
         default: flags_nxt = '0;
      endcase
   end

   assign unmasked_hit = (inv_raise_i & ~inv_mask_i) | (dnm_raise_i & ~dnm_mask_i);
   assign write_ok     = vld_i & (sup_i | ~unmasked_hit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_o      <= '0;
         flag_we_o    <= 1'b0;
         inv_sticky_o <= 1'b0;
         dnm_sticky_o <= 1'b0;
      end else begin
         flag_we_o <= write_ok;
         if (write_ok)
            flags_o <= flags_nxt;
         if (vld_i && !sup_i) begin
            if (inv_raise_i) inv_sticky_o <= 1'b1;
            if (dnm_raise_i) dnm_sticky_o <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/hcmp_flag_unit.sv
module hcmp_flag_unit
   import hcmp_pkg::*;
#(
   parameter int EXP_W = 5,
   parameter int MAN_W = 10,
   localparam int W = 1 + EXP_W + MAN_W,
   localparam int N_OPS = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             vld_i,
   input  logic             quiet_i,
   input  logic [W-1:0]     a_i,
   input  logic [W-1:0]     b_i,
   input  logic             inv_mask_i,
   input  logic             dnm_mask_i,
   input  logic             sup_i,
   output logic [FLG_W-1:0] flags_o,
   output logic             flag_we_o,
   output logic             inv_sticky_o,
   output logic             dnm_sticky_o
);
   if (EXP_W < 2) begin : g_bad_exp
      $error("hcmp_flag_unit: EXP_W must be at least 2");
   end
   if (MAN_W < 2) begin : g_bad_man
      $error("hcmp_flag_unit: MAN_W must be at least 2");
   end

   logic [W-1:0] ops [N_OPS];
   op_class_t    cls [N_OPS];
   logic [N_OPS-1:0] any_nan, any_snan, any_dnm;
   cmp_res_e res;
   logic inv_raise, dnm_raise;

   assign ops[0] = a_i;
   assign ops[1] = b_i;

   for (genvar i = 0; i < N_OPS; i++) begin : g_cls
      hcmp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
         .op_i  (ops[i]),
         .cls_o (cls[i])
      );
      assign any_nan[i]  = cls[i].is_nan;
      assign any_snan[i] = cls[i].is_snan;
      assign any_dnm[i]  = cls[i].is_dnm;
   end

   hcmp_order #(.W(W)) u_order (
      .a_i     (a_i),
      .b_i     (b_i),
      .cls_a_i (cls[0]),
      .cls_b_i (cls[1]),
      .res_o   (res)
   );

   assign inv_raise = quiet_i ? |any_snan : |any_nan;
   assign dnm_raise = |any_dnm;

   hcmp_flag_reg u_reg (
      .clk          (clk),
      .rst_n        (rst_n),
      .vld_i        (vld_i),
      .res_i        (res),
      .inv_raise_i  (inv_raise),
      .dnm_raise_i  (dnm_raise),
      .inv_mask_i   (inv_mask_i),
      .dnm_mask_i   (dnm_mask_i),
      .sup_i        (sup_i),
      .flags_o      (flags_o),
      .flag_we_o    (flag_we_o),
      .inv_sticky_o (inv_sticky_o),
      .dnm_sticky_o (dnm_sticky_o)
   );
endmodule

// File: rtl/hcmp_flag_unit_chk.sv
module hcmp_flag_unit_chk #(
   parameter int W = 16,
   parameter int FW = 6
) (
   input logic          clk,
   input logic          rst_n,
   input logic          vld_i,
   input logic          quiet_i,
   input logic [W-1:0]  a_i,
   input logic          inv_mask_i,
   input logic          sup_i,
   input logic [FW-1:0] flags_o,
   input logic          flag_we_o,
   input logic          inv_sticky_o,
   input logic          dnm_sticky_o
);
   logic a_qnan;
   assign a_qnan = (&a_i[W-2:W-6]) & a_i[9];

   assert_fixed_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !flags_o[5] && !flags_o[4] && !flags_o[2]);

   assert_parity_unordered_R1: assert property (@(posedge clk) disable iff (!rst_n)
      flags_o[1] |-> (flags_o[3] && flags_o[0]));

   assert_idle_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !vld_i |=> !flag_we_o);

   assert_hold_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !flag_we_o |-> $stable(flags_o));

   assert_ordered_qnan_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_i && !quiet_i && a_qnan && !inv_mask_i && !sup_i) |=> !flag_we_o);

   assert_suppress_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_i && sup_i) |=> flag_we_o);

   assert_inv_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      inv_sticky_o |=> inv_sticky_o);

   assert_dnm_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      dnm_sticky_o |=> dnm_sticky_o);
endmodule

bind hcmp_flag_unit hcmp_flag_unit_chk #(.W(W), .FW(hcmp_pkg::FLG_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .vld_i        (vld_i),
   .quiet_i      (quiet_i),
   .a_i          (a_i),
   .inv_mask_i   (inv_mask_i),
   .sup_i        (sup_i),
   .flags_o      (flags_o),
   .flag_we_o    (flag_we_o),
   .inv_sticky_o (inv_sticky_o),
   .dnm_sticky_o (dnm_sticky_o)
);

// File: tb/sim_hcmp_flag_unit.sv
module sim_hcmp_flag_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        vld_i = 1'b0, quiet_i = 1'b0, inv_mask_i = 1'b1, dnm_mask_i = 1'b1, sup_i = 1'b0;
   logic [15:0] a_i = '0, b_i = '0;
   logic [5:0]  flags_o;
   logic        flag_we_o, inv_sticky_o, dnm_sticky_o;

   int n_chk = 0, n_fail = 0;
   bit done = 0;
   logic [5:0] m_flags = '0;
   logic       m_inv = 0, m_dnm = 0;

   always #2 clk = ~clk;

   hcmp_flag_unit u0 (.*);

   function automatic bit is_nan(logic [15:0] x);
      return (x[14:10] == 5'h1f) && (x[9:0] != 0);
   endfunction
   function automatic bit is_snan(logic [15:0] x);
      return is_nan(x) && !x[9];
   endfunction
   function automatic bit is_dnm(logic [15:0] x);
      return (x[14:10] == 0) && (x[9:0] != 0);
   endfunction
   function automatic int key(logic [15:0] x);
      return x[15] ? -int'(x[14:0]) : int'(x[14:0]);
   endfunction
   // carry bit0, parity bit1, zero bit3
   function automatic logic [5:0] ref_flags(logic [15:0] a, logic [15:0] b);
      if (is_nan(a) || is_nan(b)) return 6'b001011;
      if (key(a) > key(b))        return 6'b000000;
      if (key(a) < key(b))        return 6'b000001;
      return 6'b001000;
   endfunction
   function automatic string tag_of(logic [5:0] f);
      case (f)
         6'b001011: return "R1";
         6'b000000: return "R2";
         6'b000001: return "R3";
         default:   return "R4";
      endcase
   endfunction

   task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s got %h expected %h", req, got, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   task automatic do_op(logic [15:0] a, logic [15:0] b, bit q, bit im, bit dm, bit sp);
      bit inv, dnm, we;
      logic [5:0] f;
      @(negedge clk);
      vld_i = 1; a_i = a; b_i = b; quiet_i = q;
      inv_mask_i = im; dnm_mask_i = dm; sup_i = sp;
      f   = ref_flags(a, b);
      inv = q ? (is_snan(a) || is_snan(b)) : (is_nan(a) || is_nan(b));
      dnm = is_dnm(a) || is_dnm(b);
      we  = sp || !((inv && !im) || (dnm && !dm));
      if (we) m_flags = f;
      if (!sp) begin m_inv |= inv; m_dnm |= dnm; end
      @(posedge clk); #1;
      vld_i = 0;
      chk(sp ? "R9" : "R8", {7'd0, flag_we_o}, {7'd0, we});
      chk(we ? tag_of(f) : "R8", {2'd0, flags_o}, {2'd0, m_flags});
      chk(q ? "R6 quiet" : "R6 ordered", {7'd0, inv_sticky_o}, {7'd0, m_inv});
      chk("R7 R11", {7'd0, dnm_sticky_o}, {7'd0, m_dnm});
   endtask

   function automatic logic [15:0] rnd_op();
      logic [15:0] r = 16'($urandom);
      case ($urandom % 9)
         0: return {r[15], 15'd0};
         1: return {r[15], 5'd0, (r[9:0] == 0) ? 10'd1 : r[9:0]};
         2: return {r[15], 5'h1f, 10'd0};
         3: return {r[15], 5'h1f, 1'b1, r[8:0]};
         4: return {r[15], 5'h1f, 1'b0, (r[8:0] == 0) ? 9'd1 : r[8:0]};
         default: return {r[15], (r[14:10] == 5'h1f) ? 5'h1e : r[14:10], r[9:0]};
      endcase
   endfunction

   task automatic do_reset();
      @(negedge clk); rst_n = 0; vld_i = 0;
      @(negedge clk); #1;
      m_flags = '0; m_inv = 0; m_dnm = 0;
      chk("R10 reset", {flag_we_o, inv_sticky_o, flags_o}, 8'd0);
      chk("R10 reset dnm", {7'd0, dnm_sticky_o}, 8'd0);
      rst_n = 1;
   endtask

   initial begin
      #(4 * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog got timeout expected completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'h5eed_0042));
      #5;
      do_reset();
      // directed
      do_op(16'h3c00, 16'h4000, 0, 1, 1, 0);  // R3 1<2
      do_op(16'h4000, 16'h3c00, 0, 1, 1, 0);  // R2
      do_op(16'h8000, 16'h0000, 0, 1, 1, 0);  // R4 -0 == +0
      do_op(16'h0001, 16'h0000, 0, 1, 1, 0);  // R7 smallest subnormal > 0
      do_op(16'h8001, 16'h0002, 0, 1, 1, 0);  // R7 negative subnormal < positive
      do_op(16'h3c00, 16'h7e00, 1, 0, 1, 0);  // R6 quiet qNaN: no invalid, write
      chk("R5 fixed zero", {2'd0, flags_o & 6'b110100}, 8'd0);
      do_op(16'h7e00, 16'h3c00, 0, 0, 1, 0);  // R6/R8 ordered qNaN unmasked: blocked
      do_op(16'h7c01, 16'h3c00, 1, 1, 1, 0);  // R6 quiet sNaN masked
      do_op(16'h0001, 16'h3c00, 0, 1, 0, 1);  // R9 suppress
      // idle: no write, flags hold
      @(negedge clk); vld_i = 0; a_i = 16'h7e00;
      @(posedge clk); #1;
      chk("R10 idle", {flag_we_o, 1'b0, flags_o}, {2'b0, m_flags});
      // random
      for (int i = 0; i < 3000; i++) begin
         logic [15:0] a = rnd_op();
         logic [15:0] b = ($urandom % 6 == 0) ? a : rnd_op();
         do_op(a, b, bit'($urandom % 2), bit'($urandom % 4 != 0),
               bit'($urandom % 4 != 0), bit'($urandom % 8 == 0));
         if (i == 1500) do_reset();
      end
      finish_run();
   end
endmodule